// File: doc/BRIEF.md
# CPU Address Decode Window Unit

This unit sits between a CPU master and a set of downstream targets and steers each transaction address to one of them. It holds five programmable decode windows. Each window has an enable bit, a 4-bit target ID, a base, a size and a remap value. For every 40-bit address presented on its input, the unit finds the enabled window that claims the address. It then reports that window's target ID, raises a hit flag and produces the translated address. When no window claims the address, the unit flags a miss.

Base, size and remap are all counted in 64 KB blocks. A size field is a run of ones filling the field from its LSB upward, so a window spans (field + 1) × 64 KB. That span is always a power of two, and the base is aligned to it. The remap value replaces the address bits above the window offset, which lets a window point at a different physical region. Software reaches the registers through a small write/read port. To reconfigure a window safely, software first clears the window's enable bit, then writes base, remap and size, and finally writes target and enable together.

The decode path from address to outputs is purely combinational. A register write takes effect on the clock edge that samples the write strobe.

Top module: `addr_win_decoder`

## Requirements
- R1: After a synchronous active-high reset, window 0 is enabled with target 0, base 0, size field 0x7FFF (2 GB) and remap 0. Every register of windows 1 to 4 reads as zero.
- R2: A window hits when it is enabled and (addr[39:16] & ~size) equals (base & ~size). In this compare, base and size are zero-extended from 16 to 24 bits.
- R3: A window spans exactly (size field + 1) × 64 KB. The last byte of that span hits, and the byte just past it does not.
- R4: A window whose enable bit is clear never hits, whatever its base, size, remap and target registers hold.
- R5: On a hit, out_addr[39:16] is (remap & ~size) | (addr[39:16] & size), and out_addr[15:0] equals in_addr[15:0].
- R6: When several enabled windows match, the lowest-numbered one supplies the target ID and the translation.
- R7: When no window hits, miss is 1, hit is 0, tgt_id is 0xF and out_addr equals in_addr.
- R8: Register map: reg_addr[4:2] selects the window and reg_addr[1:0] selects the register (0 control, 1 base, 2 size, 3 remap). Control holds enable at bit 0 and target at bits [7:4]. Base, size and remap occupy bits [15:0]. Unused bits read as zero.
- R9: A write takes effect on the rising edge where reg_we is 1, and not earlier. The read data returns the stored value combinationally.
- R10: Any address with a nonzero bit in [39:32] misses.
- R11: A write to a window index of 5 or above changes nothing, and a read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Window index [4:2] and register select [1:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| in_addr | input | 40 | Transaction address to decode |
| hit | output | 1 | An enabled window claims in_addr |
| miss | output | 1 | No window claims in_addr |
| tgt_id | output | 4 | Target of the winning window, 0xF on a miss |
| out_addr | output | 40 | Translated address, or in_addr on a miss |

## Verification
The bench probes both edges of each window: the last byte inside and the first byte beyond. A design that miscounts the size mask by one block would hit beyond the window or miss inside it. It places a window wholly inside another and then disables the lower-numbered one. A reversed priority order would return the wrong target, and a design that ignores the enable bit would keep hitting the stale window. It also decodes a window whose remap differs from its base, where an offset mask that is too wide or too narrow yields a wrong translated address. Finally, it checks that high-address bits force a miss, that writes to non-existent windows have no effect, and that a write does not show before its clock edge.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int GRAN_W  = 16;
  localparam int FIELD_W = 16;
  localparam int TGT_W   = 4;
  localparam int DATA_W  = 32;

  typedef enum logic [1:0] {
    RK_CTRL  = 2'd0,
    RK_BASE  = 2'd1,
    RK_SIZE  = 2'd2,
    RK_REMAP = 2'd3
  } reg_kind_e;

  typedef struct packed {
    logic               en;
    logic [TGT_W-1:0]   tgt;
    logic [FIELD_W-1:0] base;
    logic [FIELD_W-1:0] size;
    logic [FIELD_W-1:0] remap;
  } win_cfg_t;

  localparam win_cfg_t WIN_OFF   = '0;
  localparam win_cfg_t WIN0_BOOT = '{en: 1'b1, tgt: '0, base: '0,
                                     size: 16'h7FFF, remap: '0};
endpackage

// File: rtl/awd_regs.sv
module awd_regs
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [RA_W-1:0]             ra,
  input  logic [DATA_W-1:0]           wdata,
  output logic [DATA_W-1:0]           rdata,
  output win_cfg_t [NUM_WIN-1:0]      cfg
);
  logic [IDX_W-1:0] idx;
  reg_kind_e        kind;
  logic             idx_ok;

  assign idx    = ra[RA_W-1:2];
  assign kind   = reg_kind_e'(ra[1:0]);
  assign idx_ok = (32'(idx) < NUM_WIN);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam win_cfg_t RST_VAL = (w == 0) ? WIN0_BOOT : WIN_OFF;
    logic sel;
    assign sel = we && idx_ok && (idx == IDX_W'(w));
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg[w] <= RST_VAL;
      end else if (sel) begin
        case (kind)
          RK_CTRL: begin
            cfg[w].en  <= wdata[0];
            cfg[w].tgt <= wdata[7:4];
          end
          RK_BASE:  cfg[w].base  <= wdata[FIELD_W-1:0];
          RK_SIZE:  cfg[w].size  <= wdata[FIELD_W-1:0];
          default:  cfg[w].remap <= wdata[FIELD_W-1:0];
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (idx_ok) begin
      case (kind)
        RK_CTRL:  rdata = DATA_W'({cfg[idx].tgt, 3'b000, cfg[idx].en});
        RK_BASE:  rdata = DATA_W'(cfg[idx].base);
        RK_SIZE:  rdata = DATA_W'(cfg[idx].size);
        default:  rdata = DATA_W'(cfg[idx].remap);
      endcase
    end
  end

  // R1: boot values right after reset
  a_r1_boot_window: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg[0].en && cfg[0].tgt == '0 && cfg[0].base == '0 &&
                    cfg[0].size == 16'h7FFF && cfg[0].remap == '0));

  // R9: a base write lands on the sampling edge
  a_r9_base_write_lands: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && $past(idx_ok) && $past(kind) == RK_BASE)
      |-> cfg[$past(idx)].base == $past(wdata[FIELD_W-1:0]));

  // R11: out-of-range writes leave every window untouched
  a_r11_bad_index_inert: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(we) && !$past(idx_ok)) |-> cfg == $past(cfg));
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match
  import awd_pkg::*;
#(
  parameter int ADDR_W = 40,
  localparam int UP_W  = ADDR_W - GRAN_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  win_cfg_t          cfg,
  output logic              match,
  output logic [ADDR_W-1:0] xlat
);
  logic [UP_W-1:0] a_up, b_up, r_up, s_up;

  assign a_up = addr[ADDR_W-1:GRAN_W];
  assign b_up = UP_W'(cfg.base);
  assign r_up = UP_W'(cfg.remap);
  assign s_up = UP_W'(cfg.size);

  assign match = cfg.en && ((a_up & ~s_up) == (b_up & ~s_up));
  assign xlat  = {(r_up & ~s_up) | (a_up & s_up), addr[GRAN_W-1:0]};
endmodule

// File: rtl/awd_prio_sel.sv
module awd_prio_sel
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 40,
  localparam int IDX_W  = $clog2(NUM_WIN)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_WIN-1:0]              match_vec,
  input  logic [NUM_WIN-1:0]              en_vec,
  input  logic [NUM_WIN-1:0][ADDR_W-1:0]  xlat_vec,
  input  logic [NUM_WIN-1:0][TGT_W-1:0]   tgt_vec,
  input  logic [ADDR_W-1:0]               addr,
  output logic                            hit,
  output logic                            miss,
  output logic [TGT_W-1:0]                tgt,
  output logic [ADDR_W-1:0]               out_addr
);
  logic [IDX_W-1:0] sel;

  always_comb begin
    hit = 1'b0;
    sel = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_vec[i]) begin
        hit = 1'b1;
        sel = IDX_W'(i);
      end
    end
  end

  assign miss     = !hit;
  assign tgt      = hit ? tgt_vec[sel]  : {TGT_W{1'b1}};
  assign out_addr = hit ? xlat_vec[sel] : addr;

  // R6: winner matches and no lower-numbered window matches
  a_r6_lowest_wins: assert property (@(posedge clk) disable iff (rst)
    hit |-> (match_vec[sel] &&
             (match_vec & ((NUM_WIN'(1) << sel) - NUM_WIN'(1))) == '0));

  // R4: the chosen window is enabled in the register bank
  a_r4_winner_enabled: assert property (@(posedge clk) disable iff (rst)
    hit |-> en_vec[sel]);
endmodule

// File: rtl/addr_win_decoder.sv
module addr_win_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 5,
  parameter int ADDR_W  = 40,
  localparam int IDX_W  = $clog2(NUM_WIN),
  localparam int RA_W   = IDX_W + 2,
  localparam int HI_LSB = GRAN_W + FIELD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [ADDR_W-1:0] in_addr,
  output logic              hit,
  output logic              miss,
  output logic [TGT_W-1:0]  tgt_id,
  output logic [ADDR_W-1:0] out_addr
);
  win_cfg_t [NUM_WIN-1:0]             cfg;
  logic [NUM_WIN-1:0]                 match_vec, en_vec;
  logic [NUM_WIN-1:0][ADDR_W-1:0]     xlat_vec;
  logic [NUM_WIN-1:0][TGT_W-1:0]      tgt_vec;

  awd_regs #(.NUM_WIN(NUM_WIN)) i_regs (
    .clk(clk), .rst(rst), .we(reg_we), .ra(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .cfg(cfg)
  );

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_match
    awd_win_match #(.ADDR_W(ADDR_W)) i_match (
      .addr(in_addr), .cfg(cfg[w]),
      .match(match_vec[w]), .xlat(xlat_vec[w])
    );
    assign en_vec[w]  = cfg[w].en;
    assign tgt_vec[w] = cfg[w].tgt;
  end

  awd_prio_sel #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) i_sel (
    .clk(clk), .rst(rst), .match_vec(match_vec), .en_vec(en_vec),
    .xlat_vec(xlat_vec), .tgt_vec(tgt_vec), .addr(in_addr),
    .hit(hit), .miss(miss), .tgt(tgt_id), .out_addr(out_addr)
  );

  // R7: miss passes the address and flags the no-target code
  a_r7_miss_passthru: assert property (@(posedge clk) disable iff (rst)
    miss |-> (!hit && tgt_id == {TGT_W{1'b1}} && out_addr == in_addr));

  // R5: the offset within the 64 KB block is never rewritten
  a_r5_offset_kept: assert property (@(posedge clk) disable iff (rst)
    hit |-> out_addr[GRAN_W-1:0] == in_addr[GRAN_W-1:0]);

  // R10: bits above the base field force a miss
  a_r10_high_bits_miss: assert property (@(posedge clk) disable iff (rst)
    (in_addr[ADDR_W-1:HI_LSB] != '0) |-> miss);
endmodule

// File: tb/test_addr_win_decoder.sv
module test_addr_win_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [39:0] in_addr = '0;
  logic        hit, miss;
  logic [3:0]  tgt_id;
  logic [39:0] out_addr;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  addr_win_decoder i_addr_win_decoder (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .in_addr(in_addr),
    .hit(hit), .miss(miss), .tgt_id(tgt_id), .out_addr(out_addr)
  );

  // {address, hit, target, translated address}
  localparam logic [84:0] VEC [12] = '{
    {40'h00_1234_5678, 1'b1, 4'h0, 40'h00_1234_5678}, // R2 w0
    {40'h00_7FFF_FFFF, 1'b1, 4'h0, 40'h00_7FFF_FFFF}, // R3 w0 last byte
    {40'h00_8000_0000, 1'b1, 4'h2, 40'h00_8000_0000}, // R3 w1 first byte
    {40'h00_8FFF_FFFF, 1'b1, 4'h2, 40'h00_8FFF_FFFF}, // R3 w1 last byte
    {40'h00_9000_0000, 1'b0, 4'hF, 40'h00_9000_0000}, // R3 R7 past w1
    {40'h00_F001_2345, 1'b1, 4'h7, 40'h00_1FFF_2345}, // R5 remap
    {40'h00_F000_0010, 1'b1, 4'h7, 40'h00_1FFE_0010}, // R5 remap
    {40'h00_F002_0000, 1'b0, 4'hF, 40'h00_F002_0000}, // R3 past w2
    {40'h00_7000_0000, 1'b1, 4'h0, 40'h00_7000_0000}, // R6 w0 over w3
    {40'h00_FFF8_0000, 1'b1, 4'h4, 40'h00_FFF8_0000}, // R2 w4
    {40'h01_0000_0000, 1'b0, 4'hF, 40'h01_0000_0000}, // R10
    {40'hFF_FFFF_FFFF, 1'b0, 4'hF, 40'hFF_FFFF_FFFF}  // R10
  };

  task automatic chk(input string req, input logic [39:0] got,
                     input logic [39:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(input int w, input int k, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1;
    reg_addr = 5'((w << 2) | k);
    reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input string req, input int w, input int k,
                    input logic [31:0] exp);
    reg_addr = 5'((w << 2) | k);
    #2;
    chk(req, 40'(reg_rdata), 40'(exp));
  endtask

  task automatic dec(input string req, input logic [39:0] a, input logic h,
                     input logic [3:0] t, input logic [39:0] o);
    in_addr = a;
    #2;
    chk({req, " hit"}, 40'(hit), 40'(h));
    chk({req, " miss"}, 40'(miss), 40'(!h));
    chk({req, " tgt"}, 40'(tgt_id), 40'(t));
    chk({req, " out"}, out_addr, o);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    rd("R1 w0 ctrl", 0, 0, 32'h1);
    rd("R1 w0 size", 0, 2, 32'h7FFF);
    rd("R1 w0 base", 0, 1, 32'h0);
    for (int k = 0; k < 4; k++) rd("R1 w1 zero", 1, k, 32'h0);
    rd("R1 w4 ctrl", 4, 0, 32'h0);
    dec("R1 boot decode", 40'h00_8000_0000, 1'b0, 4'hF, 40'h00_8000_0000);

    // configure windows 1..4 in the safe order
    wr(1, 1, 32'h8000); wr(1, 3, 32'h8000); wr(1, 2, 32'h0FFF); wr(1, 0, 32'h21);
    wr(2, 1, 32'hF000); wr(2, 3, 32'h1FFE); wr(2, 2, 32'h0001); wr(2, 0, 32'h71);
    wr(3, 1, 32'h7000); wr(3, 3, 32'h0500); wr(3, 2, 32'h00FF); wr(3, 0, 32'h81);
    wr(4, 1, 32'hFFF0); wr(4, 3, 32'hFFF0); wr(4, 2, 32'h000F); wr(4, 0, 32'h41);

    for (int i = 0; i < 12; i++)
      dec("R2 R3 R5 R6 R7 R10 table", VEC[i][84:45], VEC[i][44],
          VEC[i][43:40], VEC[i][39:0]);

    // R8 readback layout and masking
    rd("R8 w2 ctrl", 2, 0, 32'h71);
    rd("R8 w2 remap", 2, 3, 32'h1FFE);
    wr(4, 3, 32'hABCD_FFF0);
    rd("R8 upper bits dropped", 4, 3, 32'hFFF0);

    // R11 out-of-range index
    wr(5, 1, 32'h1234);
    wr(7, 0, 32'hFF);
    rd("R11 read idx5", 5, 1, 32'h0);
    rd("R11 read idx7", 7, 0, 32'h0);
    dec("R11 decode unchanged", 40'h00_9000_0000, 1'b0, 4'hF, 40'h00_9000_0000);

    // R9 write not visible before its edge
    @(negedge clk);
    in_addr = 40'h00_9000_0000;
    reg_we = 1'b1; reg_addr = 5'((1 << 2) | 2); reg_wdata = 32'h1FFF;
    #2;
    chk("R9 before edge", 40'(hit), 40'h0);
    @(negedge clk);
    reg_we = 1'b0;
    #2;
    chk("R9 after edge hit", 40'(hit), 40'h1);
    chk("R9 after edge tgt", 40'(tgt_id), 40'h2);

    // R4/R6 disable window 0: nested window 3 now wins, low DRAM misses
    wr(0, 0, 32'h0);
    dec("R6 w3 after w0 off", 40'h00_7000_0000, 1'b1, 4'h8, 40'h00_0500_0000);
    dec("R4 w0 disabled", 40'h00_1234_5678, 1'b0, 4'hF, 40'h00_1234_5678);
    // R4 clear enable of w4 while its other fields stay set
    wr(4, 0, 32'h40);
    dec("R4 w4 disabled", 40'h00_FFF8_0000, 1'b0, 4'hF, 40'h00_FFF8_0000);
    rd("R4 w4 base kept", 4, 1, 32'hFFF0);

    // R1 reset again restores boot state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd("R1 w3 cleared", 3, 0, 32'h0);
    dec("R1 w0 restored", 40'h00_1234_5678, 1'b1, 4'h0, 40'h00_1234_5678);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule